// File: doc/BRIEF.md
# Pager synchronization mode controller

This block decides when a paging receiver is powered and how it regains lock on the batch stream. A batch is one sync codeword followed by sixteen frame codewords, seventeen codeword slots in all. A cycle is a configurable number of batches. Upstream logic decodes the bit stream and reports single-clock event pulses: sync word seen, preamble seen, any valid codeword seen, own address matched, call continues, and time-out expired. A strobe `cw_tick` marks the end of every codeword slot. The controller keeps its own slot and batch counters from that strobe. It re-aligns them whenever a sync word is taken.

In steady operation the receiver wakes only for the one programmed batch of each cycle. When the sync word is missed there, the block first tries a short recovery. It then falls back to a transmitter-off mode that watches only the first batch of every cycle and starts an external time-out timer. That mode widens the sync search window as time passes. When the time-out expires, a long recovery mode listens in short windows once per cycle. Each window is extended for as long as valid codewords keep arriving.

Top module: `pager_sync_ctrl`

## Requirements
- R1: Mode codes are 0 carrier detect, 1 preamble receive, 2 batch-zero search, 3 cycle receive, 4 short fade, 5 transmitter off, 6 second preamble receive, 7 long fade. After reset: mode 0, `rx_en` 1, `win_tol` 2, slot 0 of batch 0, and `tmr_start` high until the first clock edge after reset is released.
- R2: In mode 0, `rx_en` is high for one codeword slot in every 18. Event pulses arriving while `rx_en` is 0 are ignored in every mode except the time-out. In mode 0: sync goes to mode 2, preamble goes to mode 1, time-out goes to mode 7.
- R3: In modes 1 and 6, 17 codeword slots in a row without a preamble leave the mode. Mode 1 goes to mode 0 and pulses `tmr_start`. Mode 6 goes to mode 5 without pulsing `tmr_start`.
- R4: A sync in mode 2 enters mode 3 and sets the position to slot 1 of batch 0. Any other accepted sync sets the slot to 1 and keeps the batch.
- R5: In mode 3, `rx_en` is high only in batch `prog_batch`. If slot 0 of that batch ends without a sync, the mode becomes 4 and the position counters keep running.
- R6: An address match followed by a call-continues pulse in the same batch keeps `rx_en` high through the next batch. Once a batch ends without such a pulse, the extension stops.
- R7: Mode 4 keeps listening in `prog_batch` and also listens in slot 0 of the batch after it. A sync goes to mode 3 and a preamble goes to mode 1. If that slot ends with neither, the mode becomes 5 and `tmr_start` pulses.
- R8: In mode 5, `rx_en` is high only in slot 0 of batch 0, so the programmed batch is not received. Sync goes to mode 2, preamble goes to mode 6, time-out goes to mode 7.
- R9: `win_tol` is 2 outside modes 5 and 6. In modes 5 and 6, E counts the whole periods of S codeword slots since mode 5 was entered from another mode. S is set per rate: `rate_sel` 0, 1, 2 (3 acts as 2) select STEP_LO, STEP_MID, STEP_HI. E is mapped to a stage k: 0 if E=0, 1 if E=1, 2 if E is 2 or 3, and 3 otherwise. Let h be 2, 1, 0 for `rate_sel` 0, 1, 2. Then `win_tol` is 4 shifted left by max(0, k-h).
- R10: On entry to mode 7, `rx_en` is 0 until the slot counter next wraps to slot 0 of batch 0. `rx_en` then stays high for 2 slots, and each slot that contains a codeword-found pulse keeps the remaining count unchanged. In mode 7, sync goes to mode 2 and preamble goes to mode 1.
- R11: When events arrive together, sync takes priority over preamble, and preamble takes priority over time-out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cw_tick | input | 1 | End of a codeword slot |
| sync_hit | input | 1 | Sync word detected |
| pre_hit | input | 1 | Preamble detected |
| cw_hit | input | 1 | Any valid codeword detected |
| addr_hit | input | 1 | Own address matched |
| call_more | input | 1 | Current call continues past this batch |
| tmo_hit | input | 1 | Time-out timer expired |
| cyc_last | input | BW | Index of the last batch in a cycle |
| prog_batch | input | BW | Programmed receive batch |
| rate_sel | input | 2 | Bit rate: 0 low, 1 mid, 2/3 high |
| rx_en | output | 1 | Receiver enable |
| mode | output | 3 | Current mode code |
| tmr_start | output | 1 | One-clock start pulse for the time-out timer |
| win_tol | output | 6 | Sync window half-width in bits |

## Verification
The hardest state to reach from the ports is long fade recovery just after its wrap point. To get there, the block must lose sync in cycle receive and fail the short-fade check slot. It must then pass through transmitter off and a preamble detour, and finally take a time-out. The bench drives that whole chain as one directed walk. It uses a random cycle length, programmed batch, bit rate and idle gaps, and it tracks the slot and batch position in its own model. From that position it predicts the exact slot in which the listening window opens. It then sends one codeword-found pulse to show that the window is stretched by one slot.

// File: rtl/pager_sync_ctrl.sv
module pager_sync_ctrl #(
  parameter int BW       = 4,
  parameter int CPB      = 17,
  parameter int CDIV     = 18,
  parameter int LF_WIN   = 2,
  parameter int TW       = 16,
  parameter int STEP_LO  = 480,
  parameter int STEP_MID = 1125,
  parameter int STEP_HI  = 2250
)(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cw_tick,
  input  logic          sync_hit,
  input  logic          pre_hit,
  input  logic          cw_hit,
  input  logic          addr_hit,
  input  logic          call_more,
  input  logic          tmo_hit,
  input  logic [BW-1:0] cyc_last,
  input  logic [BW-1:0] prog_batch,
  input  logic [1:0]    rate_sel,
  output logic          rx_en,
  output logic [2:0]    mode,
  output logic          tmr_start,
  output logic [5:0]    win_tol
);
  localparam int SW = $clog2(CPB);
  localparam int CW = $clog2(CDIV);
  localparam int LW = $clog2(LF_WIN + 2);

  localparam logic [2:0] M_CAR = 3'd0, M_PRE = 3'd1, M_B0 = 3'd2, M_CYC = 3'd3,
                         M_SF = 3'd4, M_TXO = 3'd5, M_PR2 = 3'd6, M_LF = 3'd7;

  logic [SW-1:0] slot, qcnt;
  logic [BW-1:0] batch;
  logic [CW-1:0] cd;
  logic [LW-1:0] lf_left;
  logic [TW-1:0] ucnt, step_len;
  logic [2:0]    units, nxt;
  logic [1:0]    stage, sh;
  logic          lf_wait, lf_hit, call_on, more_pend, ext, tst;

  wire s = sync_hit & rx_en;
  wire p = pre_hit & rx_en;
  wire c = cw_hit & rx_en;
  wire a = addr_hit & rx_en;
  wire m = call_more & rx_en;

  wire           batch_end = cw_tick && slot == SW'(CPB - 1);
  wire           wrap      = batch_end && batch >= cyc_last;
  wire [BW-1:0]  nextb     = (prog_batch >= cyc_last) ? '0 : prog_batch + BW'(1);
  wire           at_prog   = batch == prog_batch;
  wire           chk_slot  = slot == '0 && batch == nextb;
  wire           q_end     = cw_tick && qcnt == SW'(CPB - 1) && !p;
  wire           more_now  = more_pend | (m & (call_on | a));
  wire           in_to     = mode == M_TXO || mode == M_PR2;
  wire           nxt_to    = nxt == M_TXO || nxt == M_PR2;
  wire           nxt_call  = nxt == M_CYC || nxt == M_SF;

  assign tmr_start = tst;

  always_comb begin
    case (mode)
      M_CAR:   rx_en = cd == '0;
      M_CYC:   rx_en = at_prog | ext;
      M_SF:    rx_en = at_prog | ext | chk_slot;
      M_TXO:   rx_en = slot == '0 && batch == '0;
      M_LF:    rx_en = !lf_wait && lf_left != '0;
      default: rx_en = 1'b1;
    endcase
  end

  always_comb begin
    nxt = mode;
    case (mode)
      M_CAR: if (s) nxt = M_B0; else if (p) nxt = M_PRE; else if (tmo_hit) nxt = M_LF;
      M_PRE: if (s) nxt = M_B0; else if (q_end) nxt = M_CAR;
      M_B0:  if (s) nxt = M_CYC;
      M_CYC: if (cw_tick && slot == '0 && at_prog && !s) nxt = M_SF;
      M_SF:  if (s) nxt = M_CYC; else if (p) nxt = M_PRE;
             else if (cw_tick && chk_slot) nxt = M_TXO;
      M_TXO: if (s) nxt = M_B0; else if (p) nxt = M_PR2; else if (tmo_hit) nxt = M_LF;
      M_PR2: if (s) nxt = M_B0; else if (tmo_hit) nxt = M_LF; else if (q_end) nxt = M_TXO;
      default: if (s) nxt = M_B0; else if (p) nxt = M_PRE;
    endcase
  end

  always_comb begin
    case (rate_sel)
      2'd0:    begin step_len = TW'(STEP_LO);  sh = 2'd2; end
      2'd1:    begin step_len = TW'(STEP_MID); sh = 2'd1; end
      default: begin step_len = TW'(STEP_HI);  sh = 2'd0; end
    endcase
  end

  assign stage   = units >= 3'd4 ? 2'd3 : units >= 3'd2 ? 2'd2 : units != '0 ? 2'd1 : 2'd0;
  assign win_tol = in_to ? ((stage > sh) ? (6'd4 << (stage - sh)) : 6'd4) : 6'd2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode <= M_CAR;  tst <= 1'b1;
      slot <= '0;     batch <= '0;   cd <= '0;   qcnt <= '0;
      call_on <= 1'b0; more_pend <= 1'b0; ext <= 1'b0;
      lf_wait <= 1'b1; lf_left <= '0; lf_hit <= 1'b0;
      ucnt <= '0;     units <= '0;
    end else begin
      mode <= nxt;
      tst  <= (nxt == M_CAR && mode != M_CAR) ||
              (nxt == M_TXO && mode != M_TXO && mode != M_PR2);

      if (s) begin
        slot <= SW'(1);
        if (mode == M_B0) batch <= '0;
      end else if (cw_tick) begin
        if (batch_end) begin
          slot  <= '0;
          batch <= wrap ? '0 : batch + BW'(1);
        end else begin
          slot <= slot + SW'(1);
        end
      end

      if (nxt != mode) cd <= '0;
      else if (cw_tick) cd <= (cd == CW'(CDIV - 1)) ? '0 : cd + CW'(1);

      if (nxt != mode || p) qcnt <= '0;
      else if (cw_tick && qcnt != SW'(CPB - 1)) qcnt <= qcnt + SW'(1);

      if (!nxt_call) begin
        call_on <= 1'b0; more_pend <= 1'b0; ext <= 1'b0;
      end else if (batch_end) begin
        ext <= more_now; call_on <= more_now; more_pend <= 1'b0;
      end else begin
        if (a) call_on <= 1'b1;
        if (m && (call_on || a)) more_pend <= 1'b1;
      end

      if (nxt == M_LF && mode != M_LF) begin
        lf_wait <= 1'b1; lf_left <= '0; lf_hit <= 1'b0;
      end else if (mode == M_LF && cw_tick) begin
        if (lf_wait) begin
          if (wrap) begin lf_wait <= 1'b0; lf_left <= LW'(LF_WIN); end
        end else if (lf_left != '0) begin
          if (!(lf_hit || c)) begin
            lf_left <= lf_left - LW'(1);
            if (lf_left == LW'(1)) lf_wait <= 1'b1;
          end
          lf_hit <= 1'b0;
        end
      end else if (c) begin
        lf_hit <= 1'b1;
      end

      if (!nxt_to) begin
        ucnt <= '0; units <= '0;
      end else if (cw_tick && in_to && units < 3'd4) begin
        if (ucnt == step_len - TW'(1)) begin
          ucnt <= '0; units <= units + 3'd1;
        end else begin
          ucnt <= ucnt + TW'(1);
        end
      end
    end
  end

  a_r3_start_single: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_start |=> !tmr_start);

  a_r1_start_mode: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_start |-> (mode == M_CAR || mode == M_TXO));

  a_r5_cycle_exit: assert property (@(posedge clk) disable iff (!rst_n)
    mode == M_CYC |=> (mode == M_CYC || mode == M_SF));

  a_r7_short_exit: assert property (@(posedge clk) disable iff (!rst_n)
    mode == M_SF |=> (mode == M_SF || mode == M_CYC || mode == M_PRE || mode == M_TXO));

  a_r8_txoff_exit: assert property (@(posedge clk) disable iff (!rst_n)
    mode == M_TXO |=> (mode == M_TXO || mode == M_B0 || mode == M_PR2 || mode == M_LF));

  a_r9_tol_power: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(win_tol) == 1 && win_tol <= 6'd32);

  a_r10_lf_entry_off: assert property (@(posedge clk) disable iff (!rst_n)
    mode != M_LF |=> (mode != M_LF || !rx_en));
endmodule

// File: tb/test_pager_sync_ctrl.sv
module test_pager_sync_ctrl;
  logic clk = 0, rst_n = 0;
  logic cw_tick = 0, sync_hit = 0, pre_hit = 0, cw_hit = 0, addr_hit = 0, call_more = 0, tmo_hit = 0;
  logic [3:0] cyc_last, prog_batch;
  logic [1:0] rate_sel;
  logic rx_en, tmr_start;
  logic [2:0] mode;
  logic [5:0] win_tol;

  int errors = 0, checks = 0, bslot = 0, bbatch = 0, cl, pb, nb, nb2, rate, n;
  int unsigned seed;
  bit done = 0;

  localparam logic [6:0] T = 7'd1, S = 7'd2, P = 7'd4, CWH = 7'd8, A = 7'd16, MR = 7'd32, TO = 7'd64;

  always #5 clk = ~clk;

  pager_sync_ctrl #(.STEP_LO(3), .STEP_MID(4), .STEP_HI(5)) i_pager_sync_ctrl (
    .clk(clk), .rst_n(rst_n), .cw_tick(cw_tick), .sync_hit(sync_hit), .pre_hit(pre_hit),
    .cw_hit(cw_hit), .addr_hit(addr_hit), .call_more(call_more), .tmo_hit(tmo_hit),
    .cyc_last(cyc_last), .prog_batch(prog_batch), .rate_sel(rate_sel),
    .rx_en(rx_en), .mode(mode), .tmr_start(tmr_start), .win_tol(win_tol));

  function automatic int exp_tol(int r, int cnt);
    int st, u, h, k;
    st = (r == 0) ? 3 : (r == 1) ? 4 : 5;
    h  = (r == 0) ? 2 : (r == 1) ? 1 : 0;
    u  = cnt / st;
    if (u > 4) u = 4;
    k  = (u >= 4) ? 3 : (u >= 2) ? 2 : (u >= 1) ? 1 : 0;
    return (k > h) ? (4 << (k - h)) : 4;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic ev(input logic [6:0] v);
    repeat ($urandom_range(0, 2)) @(negedge clk);
    {tmo_hit, call_more, addr_hit, cw_hit, pre_hit, sync_hit, cw_tick} = v;
    @(negedge clk);
    {tmo_hit, call_more, addr_hit, cw_hit, pre_hit, sync_hit, cw_tick} = '0;
    if (v[0]) begin
      if (bslot == 16) begin
        bslot = 0;
        bbatch = (bbatch == cl) ? 0 : bbatch + 1;
      end else bslot++;
    end
  endtask

  task automatic adv_to(input int ts, input int tb);
    while (!(bslot == ts && bbatch == tb)) ev(T);
  endtask

  initial begin
    #500us;
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    seed = $urandom(32'd4711);
    cl   = $urandom_range(2, 5);
    pb   = $urandom_range(1, cl);
    rate = $urandom_range(0, 2);
    nb   = (pb == cl) ? 0 : pb + 1;
    nb2  = (nb == cl) ? 0 : nb + 1;
    cyc_last = 4'(cl); prog_batch = 4'(pb); rate_sel = 2'(rate);
    repeat (3) @(negedge clk);
    rst_n = 1;
    chk("R1 mode", mode, 0);  chk("R1 rx_en", rx_en, 1);
    chk("R1 tmr_start", tmr_start, 1);  chk("R1 win_tol", win_tol, 2);
    @(negedge clk);
    chk("R1 tmr_start drop", tmr_start, 0);

    ev(T);              chk("R2 duty off", rx_en, 0);
    ev(S);              chk("R2 ignored sync", mode, 0);
    repeat (17) ev(T);  chk("R2 duty on", rx_en, 1);
    ev(P);              chk("R2 preamble", mode, 1);
    repeat (16) ev(T);  chk("R3 still preamble", mode, 1);
    ev(T);              chk("R3 back to carrier", mode, 0);
    chk("R3 restart timer", tmr_start, 1);

    ev(S | P);          chk("R11 sync over preamble", mode, 2);
    bslot = 1;
    ev(S);              chk("R4 cycle entry", mode, 3);
    bslot = 1; bbatch = 0;
    chk("R5 off batch 0", rx_en, 0);
    adv_to(0, pb);      chk("R5 on in prog batch", rx_en, 1);
    ev(S); bslot = 1;   chk("R5 sync kept", mode, 3);
    ev(A); ev(MR);
    adv_to(0, nb);      chk("R6 extended", rx_en, 1);
    adv_to(0, nb2);     chk("R6 extension over", rx_en, 0);

    adv_to(0, pb);      chk("R5 on again", rx_en, 1);
    ev(T);              chk("R5 missed sync", mode, 4);
    chk("R5 position kept", rx_en, 1);
    adv_to(0, nb);      chk("R7 check slot on", rx_en, 1);
    ev(S); bslot = 1;   chk("R7 sync recovers", mode, 3);
    adv_to(0, pb); ev(T); chk("R7 short again", mode, 4);
    adv_to(0, nb); ev(T); chk("R7 to tx off", mode, 5);
    chk("R7 timer start", tmr_start, 1);

    n = 0;
    chk("R9 tol entry", win_tol, exp_tol(rate, n));
    chk("R8 rx off", rx_en, 0);
    ev(P);              chk("R8 ignored preamble", mode, 5);
    while (!(bslot == 0 && bbatch == 0)) begin
      ev(T); n++;
      chk("R9 tol", win_tol, exp_tol(rate, n));
      if (bslot == 0 && bbatch == pb) chk("R8 prog batch skipped", rx_en, 0);
    end
    chk("R8 batch0 on", rx_en, 1);
    ev(P | TO);         chk("R11 preamble over timeout", mode, 6);
    repeat (16) begin ev(T); n++; end
    chk("R3 pre2 held", mode, 6);
    chk("R9 tol pre2", win_tol, exp_tol(rate, n));
    ev(T); n++;         chk("R3 pre2 to tx off", mode, 5);
    chk("R3 no restart", tmr_start, 0);
    chk("R9 tol kept", win_tol, exp_tol(rate, n));
    ev(TO);             chk("R8 timeout", mode, 7);
    chk("R10 entry off", rx_en, 0);
    chk("R9 tol outside", win_tol, 2);

    while (!(bslot == 16 && bbatch == cl)) ev(T);
    chk("R10 waiting", rx_en, 0);
    ev(T);              chk("R10 window open", rx_en, 1);
    ev(CWH); ev(T); ev(T);
    chk("R10 extended", rx_en, 1);
    ev(T);              chk("R10 window closed", rx_en, 0);
    while (!(bslot == 16 && bbatch == cl)) ev(T);
    ev(T);              chk("R10 reopen", rx_en, 1);
    ev(S);              chk("R10 sync exit", mode, 2);

    @(negedge clk); rst_n = 0;
    @(negedge clk); rst_n = 1;
    bslot = 0; bbatch = 0;
    chk("R1 mode again", mode, 0);
    ev(TO);             chk("R2 carrier timeout", mode, 7);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule